// File: doc/BRIEF.md
# Interrupting GPIO Controller

A bank of general-purpose pins behind a small word-addressed register bus. Each pin can be turned into an output, in which case it drives the bit held for it in the data register, or left as an input, in which case the block samples it on every clock and copies any new level into the data register. Input transitions are latched into a sticky event register; software acknowledges an event by writing a 1 to its bit. Events that are also enabled in a mask register combine into a single level-sensitive interrupt line.

Each input pin has a control bit selecting whether it reports every transition or only a high-to-low one. An open-drain register is kept as plain storage for software. The bus accepts only full-word accesses; anything narrower is dropped and reads as zero. Pin numbering runs from the most significant register bit downward, so pin 0 sits in the top bit of every register.

Top module: `gpio_ctl`

## Requirements
- R1: Word addresses 0 to 5 select the direction, open-drain, data, event, mask and control registers in that order; a full-word read returns the register contents, and any other word address in the window reads zero and ignores writes.
- R2: An access whose bus_size is not 2'b10 (full word; 2'b00 byte, 2'b01 half-word) changes no register and reads zero.
- R3: Pin n (pin_in[n], pin_out[n], pin_oe[n]) corresponds to register bit NUM_PINS-1-n, so pin 0 is bit 31 with the default width.
- R4: A direction bit of 1 makes the pin an output: pin_oe is high and pin_out equals the pin's data bit; for a direction bit of 0 both pin_oe and pin_out are low.
- R5: Writing the event register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R6: irq is high exactly while the bitwise AND of the event and mask registers is non-zero, reflecting register changes made at the preceding clock edge.
- R7: At the first clock edge where an input pin differs from its sample at the previous edge, its data bit takes the new level.
- R8: With the pin's control bit at 0 any input transition sets its event bit; with the control bit at 1 only a high-to-low transition does.
- R9: Transitions on pins whose direction bit is 1 affect neither the data register nor the event register.
- R10: The open-drain register is read/write storage with no effect on pin_out, pin_oe or irq.
- R11: A synchronous reset clears all six registers and the previous-sample register, so a pin found high at the first edge after reset counts as a rising transition.
- R12: When a write clearing an event bit and a new transition on that pin fall on the same edge, the event bit ends set.
- R13: When a data-register write and a transition on an input pin fall on the same edge, that pin's data bit takes the pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address within the register window |
| bus_size | input | 2 | Access size: 2'b00 byte, 2'b01 half-word, 2'b10 word |
| bus_we | input | 1 | Write enable, applied at the rising edge |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for the current address and size, combinational |
| pin_in | input | NUM_PINS | Pin input levels, pin n at index n |
| pin_out | output | NUM_PINS | Pin output levels |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults, 32 pins and a 10-bit word address, so every register bit maps to a real pin and the full 1024-word window is open to random addresses, reaching the unimplemented offsets as well as the six live ones. Random register traffic mixed with sparse random pin toggles drives transitions through both control settings and both directions, while directed cases place a clear and an edge, or a data write and an edge, on the same clock edge, and check the pin-order mapping with asymmetric patterns.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // number of implemented registers and index bits needed to select them
    localparam int NUM_REGS = 6;
    localparam int SEL_W    = 3;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        RS_DIR  = 3'd0,
        RS_ODR  = 3'd1,
        RS_DAT  = 3'd2,
        RS_EVT  = 3'd3,
        RS_MSK  = 3'd4,
        RS_CTL  = 3'd5,
        RS_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic dir;
        logic odr;
        logic dat;
        logic evt;
        logic msk;
        logic ctl;
    } wr_stb_t;

    // map the low word-address bits to a register; upper bits must be zero
    function automatic reg_sel_e decode_sel(input logic [SEL_W-1:0] low,
                                            input logic upper_zero);
        reg_sel_e s;
        s = RS_NONE;
        if (upper_zero) begin
            case (low)
                3'd0:    s = RS_DIR;
                3'd1:    s = RS_ODR;
                3'd2:    s = RS_DAT;
                3'd3:    s = RS_EVT;
                3'd4:    s = RS_MSK;
                3'd5:    s = RS_CTL;
                default: s = RS_NONE;
            endcase
        end
        return s;
    endfunction

    // one-hot write strobes for a selected register
    function automatic wr_stb_t strobe_of(input reg_sel_e sel, input logic en);
        wr_stb_t t;
        t     = '0;
        t.dir = en && (sel == RS_DIR);
        t.odr = en && (sel == RS_ODR);
        t.dat = en && (sel == RS_DAT);
        t.evt = en && (sel == RS_EVT);
        t.msk = en && (sel == RS_MSK);
        t.ctl = en && (sel == RS_CTL);
        return t;
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic [N-1:0]      dir_q,
    input  logic [N-1:0]      odr_q,
    input  logic [N-1:0]      dat_q,
    input  logic [N-1:0]      evt_q,
    input  logic [N-1:0]      msk_q,
    input  logic [N-1:0]      ctl_q,
    output wr_stb_t           stb,
    output logic [N-1:0]      bus_rdata
);

    logic     word_ok;
    logic     upper_zero;
    reg_sel_e sel;

    assign word_ok    = (bus_size == ACC_WORD);
    assign upper_zero = (bus_addr[ADDR_W-1:SEL_W] == '0);
    assign sel        = decode_sel(bus_addr[SEL_W-1:0], upper_zero);
    assign stb        = strobe_of(sel, bus_we & word_ok);

    always_comb begin
        bus_rdata = '0;
        if (word_ok) begin
            case (sel)
                RS_DIR:  bus_rdata = dir_q;
                RS_ODR:  bus_rdata = odr_q;
                RS_DAT:  bus_rdata = dat_q;
                RS_EVT:  bus_rdata = evt_q;
                RS_MSK:  bus_rdata = msk_q;
                RS_CTL:  bus_rdata = ctl_q;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_r,
    input  logic [N-1:0] dir_q,
    input  logic [N-1:0] ctl_q,
    output logic [N-1:0] in_chg,
    output logic [N-1:0] ev_set
);

    // level seen at the previous edge; cleared by reset
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_r;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic moved;
        logic fell;
        assign moved     = (pin_r[i] ^ prev_q[i]) & ~dir_q[i];
        assign fell      = prev_q[i] & ~pin_r[i];
        assign in_chg[i] = moved;
        assign ev_set[i] = moved & (~ctl_q[i] | fell);
    end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_stb_t      stb,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] pin_r,
    input  logic [N-1:0] in_chg,
    input  logic [N-1:0] ev_set,
    output logic [N-1:0] dir_q,
    output logic [N-1:0] odr_q,
    output logic [N-1:0] dat_q,
    output logic [N-1:0] evt_q,
    output logic [N-1:0] msk_q,
    output logic [N-1:0] ctl_q
);

    logic [N-1:0] dat_base;
    logic [N-1:0] dat_next;
    logic [N-1:0] evt_clr;
    logic [N-1:0] evt_next;

    always_comb begin
        dat_base = stb.dat ? wdata : dat_q;
        // an input transition overrides a same-edge bus write
        dat_next = (dat_base & ~in_chg) | (pin_r & in_chg);
        evt_clr  = stb.evt ? wdata : '0;
        // a new event overrides a same-edge clear
        evt_next = (evt_q & ~evt_clr) | ev_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            odr_q <= '0;
            dat_q <= '0;
            evt_q <= '0;
            msk_q <= '0;
            ctl_q <= '0;
        end else begin
            if (stb.dir) dir_q <= wdata;
            if (stb.odr) odr_q <= wdata;
            if (stb.msk) msk_q <= wdata;
            if (stb.ctl) ctl_q <= wdata;
            dat_q <= dat_next;
            evt_q <= evt_next;
        end
    end

endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [1:0]          bus_size,
    input  logic                bus_we,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int TOP_BIT = NUM_PINS - 1;

    wr_stb_t             stb;
    logic [NUM_PINS-1:0] pin_r;
    logic [NUM_PINS-1:0] dir_q, odr_q, dat_q, evt_q, msk_q, ctl_q;
    logic [NUM_PINS-1:0] in_chg, ev_set;

    // pin n lives in register bit TOP_BIT-n
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin_map
        assign pin_r[TOP_BIT-n] = pin_in[n];
        assign pin_oe[n]        = dir_q[TOP_BIT-n];
        assign pin_out[n]       = dir_q[TOP_BIT-n] & dat_q[TOP_BIT-n];
    end

    gpio_bus_decode #(
        .N      (NUM_PINS),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_we    (bus_we),
        .dir_q     (dir_q),
        .odr_q     (odr_q),
        .dat_q     (dat_q),
        .evt_q     (evt_q),
        .msk_q     (msk_q),
        .ctl_q     (ctl_q),
        .stb       (stb),
        .bus_rdata (bus_rdata)
    );

    gpio_edge_detect #(
        .N (NUM_PINS)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pin_r  (pin_r),
        .dir_q  (dir_q),
        .ctl_q  (ctl_q),
        .in_chg (in_chg),
        .ev_set (ev_set)
    );

    gpio_regfile #(
        .N (NUM_PINS)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .stb    (stb),
        .wdata  (bus_wdata),
        .pin_r  (pin_r),
        .in_chg (in_chg),
        .ev_set (ev_set),
        .dir_q  (dir_q),
        .odr_q  (odr_q),
        .dat_q  (dat_q),
        .evt_q  (evt_q),
        .msk_q  (msk_q),
        .ctl_q  (ctl_q)
    );

    assign irq = |(evt_q & msk_q);

endmodule

// File: rtl/gpio_ctl_chk.sv
module gpio_ctl_chk #(
    parameter int N      = 32,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_we,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      pin_r,
    input logic [N-1:0]      dir_q,
    input logic [N-1:0]      odr_q,
    input logic [N-1:0]      dat_q,
    input logic [N-1:0]      evt_q,
    input logic [N-1:0]      msk_q,
    input logic [N-1:0]      ctl_q,
    input logic [N-1:0]      ev_set
);

    localparam logic [ADDR_W-1:0] EVT_ADDR = ADDR_W'(3);

    // R11: one edge of reset leaves every register zero
    a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == '0 && odr_q == '0 && dat_q == '0 &&
                        evt_q == '0 && msk_q == '0 && ctl_q == '0));

    // R5 / R12: a written 1 clears the bit unless a new event arrived together
    a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_size == 2'd2 && bus_addr == EVT_ADDR)
        |=> ((evt_q & $past(bus_wdata) & ~$past(ev_set)) == '0));

    // R2: narrow writes leave the plain storage registers untouched
    a_r2_narrow_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_size != 2'd2)
        |=> ($stable(dir_q) && $stable(odr_q) && $stable(msk_q) && $stable(ctl_q)));

    // R9: no event bit newly rises on a pin that was an output
    a_r9_output_no_event: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((evt_q & ~$past(evt_q) & $past(dir_q)) == '0));

    // R8: with control set, a new event needs the pin low at that edge
    a_r8_fall_only: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((evt_q & ~$past(evt_q) & $past(ctl_q) & $past(pin_r)) == '0));

endmodule

bind gpio_ctl gpio_ctl_chk #(
    .N      (NUM_PINS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_r     (pin_r),
    .dir_q     (dir_q),
    .odr_q     (odr_q),
    .dat_q     (dat_q),
    .evt_q     (evt_q),
    .msk_q     (msk_q),
    .ctl_q     (ctl_q),
    .ev_set    (ev_set)
);

// File: tb/gpio_ctl_tb.sv
module gpio_ctl_tb;

    localparam int N  = 32;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic          bus_we = 1'b0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    always #2 clk = ~clk;

    gpio_ctl #(.NUM_PINS(N), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // reference state, register bit order
    logic [N-1:0] m_dir = '0, m_odr = '0, m_dat = '0, m_evt = '0, m_msk = '0, m_ctl = '0, m_prev = '0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    function automatic logic [N-1:0] rev(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[N-1-i] = v[i];
        return r;
    endfunction

    function automatic logic [N-1:0] m_read(input logic [AW-1:0] a, input logic [1:0] sz);
        if (sz != 2'd2) return '0;
        case (a)
            AW'(0):  return m_dir;
            AW'(1):  return m_odr;
            AW'(2):  return m_dat;
            AW'(3):  return m_evt;
            AW'(4):  return m_msk;
            AW'(5):  return m_ctl;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at the falling edge, check read data, clock, check outputs
    task automatic step(input logic we, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [N-1:0] wd, input logic [N-1:0] pins, input string tag);
        logic [N-1:0] pr, chg, fall, set, clr, dbase;
        logic         wok;
        bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd; pin_in = pins;
        #1;
        chk({tag, " read"}, bus_rdata, m_read(a, sz));
        pr    = rev(pins);
        wok   = we && (sz == 2'd2);
        chg   = (pr ^ m_prev) & ~m_dir;
        fall  = m_prev & ~pr;
        set   = chg & (~m_ctl | fall);
        clr   = (wok && a == AW'(3)) ? wd : '0;
        dbase = (wok && a == AW'(2)) ? wd : m_dat;
        @(posedge clk);
        m_evt  = (m_evt & ~clr) | set;
        m_dat  = (dbase & ~chg) | (pr & chg);
        if (wok && a == AW'(0)) m_dir = wd;
        if (wok && a == AW'(1)) m_odr = wd;
        if (wok && a == AW'(4)) m_msk = wd;
        if (wok && a == AW'(5)) m_ctl = wd;
        m_prev = pr;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R4 pin_oe", pin_oe, rev(m_dir));
        chk("R4 pin_out", pin_out, rev(m_dir & m_dat));
        chk("R6 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_evt & m_msk)});
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        step(1'b1, a, 2'd2, d, pin_in, "R1");
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1'b0, a, 2'd2, '0, pin_in, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pins, snap;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state of all six registers
        for (int a = 0; a < 6; a++) rd(AW'(a), "R11");
        chk("R11 irq", {{(N-1){1'b0}}, irq}, '0);

        // R1: map, readback, unmapped addresses
        wr(1, 32'h1234_5678);
        wr(4, 32'h0F0F_0000);
        wr(5, 32'h0000_0000);
        for (int a = 0; a < 6; a++) rd(AW'(a), "R1");
        wr(6, 32'hFFFF_FFFF);
        wr(AW'(1023), 32'hFFFF_FFFF);
        rd(6, "R1 unmapped");
        chk("R1 unmapped zero", bus_rdata, '0);
        rd(AW'(1023), "R1 unmapped");
        rd(1, "R1 odr kept");
        chk("R1 odr value", bus_rdata, 32'h1234_5678);

        // R2: narrow write ignored, narrow read zero
        step(1'b1, 0, 2'd0, 32'hFFFF_FFFF, pin_in, "R2");
        step(1'b1, 4, 2'd1, 32'hFFFF_FFFF, pin_in, "R2");
        step(1'b0, 1, 2'd1, '0, pin_in, "R2 half read");
        chk("R2 half read zero", bus_rdata, '0);
        rd(0, "R2");
        chk("R2 dir untouched", bus_rdata, '0);

        // R3 / R4: pins 0 and 1 outputs (bits 31, 30)
        wr(0, 32'hC000_0000);
        wr(2, 32'hFFFF_FFFF);
        chk("R3 pin order out", pin_out, 32'h0000_0003);
        chk("R3 pin order oe", pin_oe, 32'h0000_0003);

        // R10: open-drain storage has no effect on pins
        snap = pin_out;
        wr(1, 32'hFFFF_FFFF);
        chk("R10 pins unchanged", pin_out, snap);

        // R7 / R8: any-edge on pin 5 (bit 26)
        wr(4, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        pins = pin_in; pins[5] = 1'b1;
        step(1'b0, 3, 2'd2, '0, pins, "R8");
        rd(3, "R8");
        chk("R8 rise any-edge", bus_rdata, 32'h0400_0000);
        chk("R6 irq asserted", {{(N-1){1'b0}}, irq}, 32'h1);
        rd(2, "R7");
        chk("R7 data follows", bus_rdata & 32'h0400_0000, 32'h0400_0000);
        // falling only
        wr(5, 32'h0400_0000);
        wr(3, 32'hFFFF_FFFF);
        chk("R5 cleared irq", {{(N-1){1'b0}}, irq}, '0);
        pins = pin_in; pins[5] = 1'b0;
        step(1'b0, 3, 2'd2, '0, pins, "R8");
        rd(3, "R8");
        chk("R8 fall captured", bus_rdata, 32'h0400_0000);
        wr(3, 32'h0400_0000);
        pins = pin_in; pins[5] = 1'b1;
        step(1'b0, 3, 2'd2, '0, pins, "R8");
        rd(3, "R8");
        chk("R8 rise ignored", bus_rdata, '0);

        // R9: toggling an output pin does nothing
        pins = pin_in; pins[0] = 1'b1; pins[1] = 1'b1;
        step(1'b0, 3, 2'd2, '0, pins, "R9");
        rd(3, "R9");
        chk("R9 no event", bus_rdata, '0);
        rd(2, "R9");
        chk("R9 data kept", bus_rdata & 32'hC000_0000, 32'hC000_0000);

        // R5: partial clear
        wr(5, 32'h0);
        pins = pin_in; pins[8] = 1'b1; pins[9] = 1'b1;
        step(1'b0, 3, 2'd2, '0, pins, "R5");
        wr(3, 32'h0080_0000);
        rd(3, "R5");
        chk("R5 partial clear", bus_rdata, 32'h0040_0000);

        // R12: clear and new edge on pin 6 (bit 25) together
        pins = pin_in; pins[6] = 1'b1;
        step(1'b1, 3, 2'd2, 32'h0240_0000, pins, "R12");
        rd(3, "R12");
        chk("R12 edge wins", bus_rdata, 32'h0200_0000);

        // R13: data write and edge on pin 7 (bit 24) together
        pins = pin_in; pins[7] = 1'b1;
        step(1'b1, 2, 2'd2, 32'h0000_0000, pins, "R13");
        rd(2, "R13");
        chk("R13 pin wins", bus_rdata & 32'h0100_0000, 32'h0100_0000);

        // random traffic
        for (int k = 0; k < 6000; k++) begin
            int unsigned op;
            logic [AW-1:0] a;
            logic [N-1:0] d;
            op   = $urandom % 8;
            d    = N'($urandom);
            pins = pin_in ^ N'($urandom & $urandom & $urandom);
            a    = AW'($urandom % 6);
            case (op)
                0, 1, 2: step(1'b1, a, 2'd2, d, pins, "R1 rnd");
                3:       step(1'b1, a, 2'($urandom % 2), d, pins, "R2 rnd");
                4:       step(1'b1, AW'($urandom), 2'd2, d, pins, "R1 rnd wide");
                default: step(1'b0, ($urandom % 4 == 0) ? AW'($urandom) : a,
                              2'($urandom), '0, pins, "R7 rnd");
            endcase
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule